// File: doc/BRIEF.md
# Voltage-Frequency Transition Sequencer

This block moves a processor package from one operating point to another. An operating point is a frequency code paired with a supply voltage code. Each of two cores writes its wanted point into its own request register. The block merges the two requests into one package target by taking the larger frequency code and the larger voltage code on their own. It then drives the transition through two handshake ports: a stepped voltage code toward the regulator, and a frequency select with a request/lock pair toward the PLL.

The direction of the move sets the order of the two halves. When the frequency rises, the voltage code climbs first, one code at a time, and the PLL is retuned only after that. When the frequency falls, the PLL is retuned first and the voltage code then walks down. Each voltage step is held for a programmable number of cycles. While the PLL is retuning, the block stalls the core and blocks snoops. That stall has a hard cycle limit, so a PLL that never reports lock cannot hang the package. A request that arrives during a transition is held and acted on once the transition ends. Only the newest such request is kept.

Top module: `pstate_seq`

## Requirements
- R1: When the target frequency code is greater than the current one, every voltage step of the transition happens before `pll_req` rises.
- R2: When the target frequency code is smaller than the current one, no voltage step happens until `pll_req` has fallen, and `vid_out` never changes while `pll_req` is high.
- R3: `vid_out` changes by exactly one code per step. Within a ramp, two steps are at least `step_hold`+1 cycles apart, and the number of steps equals the distance between the old and the new voltage code.
- R4: A request written while `busy` is high starts only after the running transition has issued `done`. Of several such writes, only the last one is carried out.
- R5: `core_stall` is high exactly while `pll_req` is high, never for more than `STALL_MAX` cycles. It ends one cycle after `pll_lock` is seen, or after exactly `STALL_MAX` cycles if lock never comes.
- R6: `snoop_block` is equal to `core_stall` in every cycle.
- R7: The package target is the larger of the two frequency codes together with the larger of the two voltage codes. Two equal requests give that same point.
- R8: If the merged target equals the current point, no transition starts: `busy`, `core_stall` and `done` stay low.
- R9: Each transition ends with `done` high for exactly one cycle, and `busy` is high throughout the transition.
- R10: After reset, `vid_out` is `BOOT_VID`, `pll_freq` is `BOOT_FREQ`, and `busy`, `done`, `pll_req`, `core_stall` and `snoop_block` are low.
- R11: `pll_freq` changes only in the cycle in which `pll_req` rises, and then takes the target frequency code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| core0_wr | input | 1 | Write strobe for the core 0 request |
| core0_freq | input | FREQ_W | Frequency code requested by core 0 |
| core0_vid | input | VID_W | Voltage code requested by core 0 |
| core1_wr | input | 1 | Write strobe for the core 1 request |
| core1_freq | input | FREQ_W | Frequency code requested by core 1 |
| core1_vid | input | VID_W | Voltage code requested by core 1 |
| step_hold | input | HOLD_W | Extra cycles each voltage step is held; must not change while busy |
| pll_lock | input | 1 | PLL reports lock on the requested frequency |
| vid_out | output | VID_W | Voltage code toward the regulator |
| pll_freq | output | FREQ_W | Frequency code toward the PLL |
| pll_req | output | 1 | PLL retune request, high during the frequency phase |
| core_stall | output | 1 | Core unavailable during the frequency phase |
| snoop_block | output | 1 | Snoops blocked during the frequency phase |
| busy | output | 1 | Transition in progress |
| done | output | 1 | One-cycle pulse at the end of a transition |

## Verification
The hardest case to reach is a deferred request that is overwritten. Two writes have to land while a ramp is still running, and then only the second one may take effect. The bench forces this case by starting a long upward voltage ramp with a nonzero step hold. It then writes an intermediate point and a final point into the same core's register a few cycles later, while `busy` is still high. It counts `done` pulses and PLL requests, and checks that the intermediate frequency never appears on `pll_freq`. The stall limit is reached by turning off the bench's PLL lock model, so that the timeout path is the only way out of the frequency phase.

// File: rtl/pstate_pkg.sv
package pstate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_VRAMP = 2'd1,
    ST_FREQ  = 2'd2,
    ST_FIN   = 2'd3
  } pst_state_e;

endpackage

// File: rtl/pstate_req_merge.sv
module pstate_req_merge #(
  parameter int NCORE     = 2,
  parameter int FREQ_W    = 4,
  parameter int VID_W     = 6,
  parameter int BOOT_FREQ = 0,
  parameter int BOOT_VID  = 0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NCORE-1:0]              wr,
  input  logic [NCORE-1:0][FREQ_W-1:0]  f_in,
  input  logic [NCORE-1:0][VID_W-1:0]   v_in,
  output logic [FREQ_W-1:0]             tgt_f,
  output logic [VID_W-1:0]              tgt_v,
  output logic                          any_wr
);

  logic [FREQ_W-1:0] f_q [NCORE];
  logic [VID_W-1:0]  v_q [NCORE];

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    always_ff @(posedge clk) begin
      if (rst) begin
        f_q[c] <= FREQ_W'(BOOT_FREQ);
        v_q[c] <= VID_W'(BOOT_VID);
      end else if (wr[c]) begin
        f_q[c] <= f_in[c];
        v_q[c] <= v_in[c];
      end
    end
  end

  // highest frequency and highest voltage, each picked on its own
  always_comb begin
    tgt_f = f_q[0];
    tgt_v = v_q[0];
    for (int c = 1; c < NCORE; c++) begin
      if (f_q[c] > tgt_f) tgt_f = f_q[c];
      if (v_q[c] > tgt_v) tgt_v = v_q[c];
    end
  end

  assign any_wr = |wr;

endmodule

// File: rtl/pstate_vid_ramp.sv
module pstate_vid_ramp #(
  parameter int VID_W    = 6,
  parameter int HOLD_W   = 8,
  parameter int BOOT_VID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [VID_W-1:0]  target,
  input  logic [HOLD_W-1:0] hold,
  output logic [VID_W-1:0]  vid,
  output logic              at_tgt
);

  localparam logic [VID_W-1:0] ONE = VID_W'(1);

  logic [HOLD_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      vid <= VID_W'(BOOT_VID);
      cnt <= '0;
    end else if (!en) begin
      cnt <= '0;
    end else if (vid != target) begin
      if (cnt == hold) begin
        vid <= (target > vid) ? vid + ONE : vid - ONE;
        cnt <= '0;
      end else begin
        cnt <= cnt + HOLD_W'(1);
      end
    end
  end

  assign at_tgt = (vid == target);

endmodule

// File: rtl/pstate_seq.sv
module pstate_seq
  import pstate_pkg::*;
#(
  parameter int FREQ_W    = 4,
  parameter int VID_W     = 6,
  parameter int HOLD_W    = 8,
  parameter int STALL_MAX = 1000,
  parameter int BOOT_FREQ = 0,
  parameter int BOOT_VID  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core0_wr,
  input  logic [FREQ_W-1:0] core0_freq,
  input  logic [VID_W-1:0]  core0_vid,
  input  logic              core1_wr,
  input  logic [FREQ_W-1:0] core1_freq,
  input  logic [VID_W-1:0]  core1_vid,
  input  logic [HOLD_W-1:0] step_hold,
  input  logic              pll_lock,
  output logic [VID_W-1:0]  vid_out,
  output logic [FREQ_W-1:0] pll_freq,
  output logic              pll_req,
  output logic              core_stall,
  output logic              snoop_block,
  output logic              busy,
  output logic              done
);

  localparam int SCW = $clog2(STALL_MAX + 1);
  localparam logic [SCW-1:0] STALL_LAST = SCW'(STALL_MAX - 1);

  pst_state_e        state, state_n;
  logic [FREQ_W-1:0] m_f, tgt_f;
  logic [VID_W-1:0]  m_v, tgt_v;
  logic              any_wr, pend, fdue, at_tgt;
  logic [SCW-1:0]    st_cnt;
  logic              freq_end, start_ok;

  pstate_req_merge #(
    .NCORE(2), .FREQ_W(FREQ_W), .VID_W(VID_W),
    .BOOT_FREQ(BOOT_FREQ), .BOOT_VID(BOOT_VID)
  ) i_merge (
    .clk(clk), .rst(rst),
    .wr({core1_wr, core0_wr}),
    .f_in({core1_freq, core0_freq}),
    .v_in({core1_vid, core0_vid}),
    .tgt_f(m_f), .tgt_v(m_v), .any_wr(any_wr)
  );

  pstate_vid_ramp #(
    .VID_W(VID_W), .HOLD_W(HOLD_W), .BOOT_VID(BOOT_VID)
  ) i_ramp (
    .clk(clk), .rst(rst),
    .en(state == ST_VRAMP),
    .target(tgt_v), .hold(step_hold),
    .vid(vid_out), .at_tgt(at_tgt)
  );

  assign start_ok = pend && ((m_f != pll_freq) || (m_v != vid_out));
  assign freq_end = pll_lock || (st_cnt == STALL_LAST);

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE: begin
        if (start_ok) state_n = (m_f < pll_freq) ? ST_FREQ : ST_VRAMP;
      end
      ST_VRAMP: begin
        if (at_tgt) state_n = fdue ? ST_FREQ : ST_FIN;
      end
      ST_FREQ: begin
        if (freq_end) state_n = (vid_out != tgt_v) ? ST_VRAMP : ST_FIN;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      pend        <= 1'b0;
      fdue        <= 1'b0;
      tgt_f       <= FREQ_W'(BOOT_FREQ);
      tgt_v       <= VID_W'(BOOT_VID);
      pll_freq    <= FREQ_W'(BOOT_FREQ);
      st_cnt      <= '0;
      pll_req     <= 1'b0;
      core_stall  <= 1'b0;
      snoop_block <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
    end else begin
      state <= state_n;
      // a write always leaves a request pending; idle consumes it
      if (any_wr)                pend <= 1'b1;
      else if (state == ST_IDLE) pend <= 1'b0;
      if (state == ST_IDLE && start_ok) begin
        tgt_f <= m_f;
        tgt_v <= m_v;
        fdue  <= (m_f != pll_freq);
      end
      if (state == ST_FREQ && freq_end) fdue <= 1'b0;
      if (state != ST_FREQ && state_n == ST_FREQ)
        pll_freq <= (state == ST_IDLE) ? m_f : tgt_f;
      st_cnt      <= (state == ST_FREQ) ? st_cnt + SCW'(1) : '0;
      pll_req     <= (state_n == ST_FREQ);
      core_stall  <= (state_n == ST_FREQ);
      snoop_block <= (state_n == ST_FREQ);
      busy        <= (state_n != ST_IDLE);
      done        <= (state_n == ST_FIN);
    end
  end

endmodule

// File: rtl/pstate_seq_chk.sv
module pstate_seq_chk #(
  parameter int FREQ_W    = 4,
  parameter int VID_W     = 6,
  parameter int HOLD_W    = 8,
  parameter int STALL_MAX = 1000
) (
  input logic              clk,
  input logic              rst,
  input logic [HOLD_W-1:0] step_hold,
  input logic [VID_W-1:0]  vid_out,
  input logic [FREQ_W-1:0] pll_freq,
  input logic              pll_req,
  input logic              core_stall,
  input logic              snoop_block,
  input logic              done
);

  localparam int SCW = $clog2(STALL_MAX + 2);
  localparam logic [VID_W-1:0]  ONE   = VID_W'(1);
  localparam logic [HOLD_W:0]   GMAX  = {(HOLD_W+1){1'b1}};
  localparam logic [SCW-1:0]    SMAXC = SCW'(STALL_MAX);

  logic [VID_W-1:0] vid_prev;
  logic [HOLD_W:0]  gap;
  logic [SCW-1:0]   srun;

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_prev <= vid_out;
      gap      <= GMAX;
      srun     <= '0;
    end else begin
      vid_prev <= vid_out;
      if (vid_out != vid_prev) gap <= '0;
      else if (gap != GMAX)    gap <= gap + 1'b1;
      if (!core_stall)         srun <= '0;
      else if (srun != SMAXC)  srun <= srun + 1'b1;
    end
  end

  p_unit_step_r3: assert property (@(posedge clk) disable iff (rst)
    (vid_out != vid_prev) |-> (vid_out == vid_prev + ONE || vid_prev == vid_out + ONE));

  p_step_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (vid_out != vid_prev) |-> (gap >= {1'b0, step_hold}));

  // R1 and R2: the voltage code is frozen during the frequency phase
  p_vid_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    pll_req |-> $stable(vid_out));

  p_stall_match_r5: assert property (@(posedge clk) disable iff (rst)
    core_stall == pll_req);

  p_stall_bound_r5: assert property (@(posedge clk) disable iff (rst)
    core_stall |-> (srun < SMAXC));

  p_snoop_r6: assert property (@(posedge clk) disable iff (rst)
    snoop_block == core_stall);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_freq_edge_r11: assert property (@(posedge clk) disable iff (rst)
    (pll_freq != $past(pll_freq)) |-> (pll_req && !$past(pll_req)));

endmodule

bind pstate_seq pstate_seq_chk #(
  .FREQ_W(FREQ_W), .VID_W(VID_W), .HOLD_W(HOLD_W), .STALL_MAX(STALL_MAX)
) i_chk (
  .clk(clk), .rst(rst), .step_hold(step_hold), .vid_out(vid_out),
  .pll_freq(pll_freq), .pll_req(pll_req), .core_stall(core_stall),
  .snoop_block(snoop_block), .done(done)
);

// File: tb/test_pstate_seq.sv
module test_pstate_seq;

  localparam int CLK_PERIOD = 10;
  localparam int FW = 3;
  localparam int VW = 4;
  localparam int HW = 4;
  localparam int SMAX = 12;
  localparam int SEQ [9] = '{3, 7, 0, 5, 1, 6, 2, 4, 0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic c0_wr = 1'b0, c1_wr = 1'b0;
  logic [FW-1:0] c0_f = '0, c1_f = '0;
  logic [VW-1:0] c0_v = '0, c1_v = '0;
  logic [HW-1:0] hold = '0;
  logic pll_lock = 1'b0;
  logic [VW-1:0] vid_out;
  logic [FW-1:0] pll_freq;
  logic pll_req, core_stall, snoop_block, busy, done;

  int nchk = 0, nfail = 0;
  int cyc = 0, nsteps, badstep, badgap, firstchg, lastchg, rise, fall;
  int nrise, stall_len, mism, ndone, nbusy, seen_f2;
  bit have_chg = 0, preq_prev = 0;
  logic [VW-1:0] pv = '0;
  int lock_delay = 1, lcnt = 0;
  bit lock_en = 1;
  int prev_f = 0, prev_v = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pstate_seq #(
    .FREQ_W(FW), .VID_W(VW), .HOLD_W(HW), .STALL_MAX(SMAX),
    .BOOT_FREQ(0), .BOOT_VID(0)
  ) i_pstate_seq (
    .clk(clk), .rst(rst),
    .core0_wr(c0_wr), .core0_freq(c0_f), .core0_vid(c0_v),
    .core1_wr(c1_wr), .core1_freq(c1_f), .core1_vid(c1_v),
    .step_hold(hold), .pll_lock(pll_lock),
    .vid_out(vid_out), .pll_freq(pll_freq), .pll_req(pll_req),
    .core_stall(core_stall), .snoop_block(snoop_block),
    .busy(busy), .done(done)
  );

  // PLL model: lock lock_delay cycles after the request is seen
  always @(posedge clk) begin
    if (pll_req) begin
      lcnt     <= lcnt + 1;
      pll_lock <= lock_en && (lcnt + 1 >= lock_delay);
    end else begin
      lcnt     <= 0;
      pll_lock <= 1'b0;
    end
  end

  task automatic clear_stats();
    nsteps = 0; badstep = 0; badgap = 0; firstchg = 0; lastchg = 0;
    rise = 0; fall = 0; nrise = 0; stall_len = 0; mism = 0;
    ndone = 0; nbusy = 0; seen_f2 = 0; have_chg = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (vid_out != pv) begin
        int d;
        d = int'(vid_out) - int'(pv);
        nsteps++;
        if (d != 1 && d != -1) badstep++;
        if (have_chg && (cyc - lastchg) < int'(hold) + 1) badgap++;
        if (!have_chg) firstchg = cyc;
        have_chg = 1;
        lastchg = cyc;
      end
      if (pll_req && !preq_prev) begin rise = cyc; nrise++; end
      if (!pll_req && preq_prev) fall = cyc;
      if (core_stall) stall_len++;
      if (core_stall != snoop_block) mism++;
      if (done) ndone++;
      if (busy) nbusy++;
      if (pll_freq == 3'd2) seen_f2++;
    end
    pv = vid_out;
    preq_prev = pll_req;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_quiet();
    int quiet = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3000 && quiet < 4; i++) begin
      @(negedge clk);
      quiet = busy ? 0 : quiet + 1;
    end
  endtask

  task automatic write_core(input int core, input int f, input int v);
    @(negedge clk);
    if (core == 0) begin c0_wr = 1'b1; c0_f = FW'(f); c0_v = VW'(v); end
    else           begin c1_wr = 1'b1; c1_f = FW'(f); c1_v = VW'(v); end
    @(negedge clk);
    c0_wr = 1'b0; c1_wr = 1'b0;
  endtask

  task automatic go(input int core, input int f, input int v,
                    input int ef, input int ev, input int d);
    int dv, exp_stall;
    bit chg, fchg;
    @(negedge clk);
    lock_delay = d;
    clear_stats();
    write_core(core, f, v);
    wait_quiet();
    dv = (ev > prev_v) ? ev - prev_v : prev_v - ev;
    chg = (ef != prev_f) || (ev != prev_v);
    fchg = (ef != prev_f);
    exp_stall = !fchg ? 0 : (!lock_en ? SMAX : ((d + 1 < SMAX) ? d + 1 : SMAX));
    chk(int'(vid_out) == ev, "R7 final vid", int'(vid_out), ev);
    chk(int'(pll_freq) == ef, "R11 final freq", int'(pll_freq), ef);
    chk(ndone == (chg ? 1 : 0), "R9 done pulses", ndone, chg ? 1 : 0);
    chk(nsteps == dv, "R3 step count", nsteps, dv);
    chk(badstep == 0, "R3 step size", badstep, 0);
    chk(badgap == 0, "R3 step spacing", badgap, 0);
    chk(stall_len == exp_stall, "R5 stall length", stall_len, exp_stall);
    chk(mism == 0, "R6 snoop equals stall", mism, 0);
    if (!chg) chk(nbusy == 0, "R8 no-op busy", nbusy, 0);
    if (ef > prev_f && nsteps > 0)
      chk(lastchg < rise, "R1 voltage before frequency", lastchg, rise);
    if (ef < prev_f && nsteps > 0)
      chk(firstchg > fall, "R2 frequency before voltage", firstchg, fall);
    prev_f = ef;
    prev_v = ev;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL R9 watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(vid_out == '0, "R10 reset vid", int'(vid_out), 0);
    chk(pll_freq == '0, "R10 reset freq", int'(pll_freq), 0);
    chk(!busy && !done, "R10 reset busy/done", int'(busy) + int'(done), 0);
    chk(!pll_req && !core_stall && !snoop_block, "R10 reset stall",
        int'(pll_req) + int'(core_stall) + int'(snoop_block), 0);

    // sweep: step hold and PLL lock delay, up and down moves over all codes
    foreach (SEQ[k]) begin end
    for (int hi = 0; hi < 2; hi++) begin
      hold = HW'(hi * 2);
      for (int di = 0; di < 2; di++) begin
        for (int k = 0; k < 9; k++)
          go(0, SEQ[k], 2 * SEQ[k] + 1, SEQ[k], 2 * SEQ[k] + 1, 1 + 2 * di);
      end
    end

    // R7: merge of the two cores, field by field
    hold = HW'(1);
    go(0, 5, 3, 5, 3, 2);
    go(1, 2, 9, 5, 9, 2);     // frequency equal, voltage only
    go(1, 6, 13, 6, 13, 2);
    // R8: merged target unchanged
    go(0, 6, 13, 6, 13, 2);   // equal requests
    go(1, 0, 0, 6, 13, 2);
    go(0, 1, 3, 1, 3, 2);

    // R4: two writes during a ramp, only the last one runs
    hold = HW'(2);
    @(negedge clk);
    clear_stats();
    write_core(0, 4, 9);
    repeat (3) @(negedge clk);
    chk(busy, "R4 busy during ramp", int'(busy), 1);
    write_core(0, 2, 5);
    write_core(0, 7, 15);
    wait_quiet();
    chk(ndone == 2, "R4 transitions after deferral", ndone, 2);
    chk(nrise == 2, "R4 PLL requests after deferral", nrise, 2);
    chk(seen_f2 == 0, "R4 overwritten request skipped", seen_f2, 0);
    chk(int'(vid_out) == 15, "R4 final vid", int'(vid_out), 15);
    chk(int'(pll_freq) == 7, "R4 final freq", int'(pll_freq), 7);
    prev_f = 7;
    prev_v = 15;

    // R5: PLL never locks, stall ends at the limit
    lock_en = 0;
    go(0, 3, 7, 3, 7, 100);
    lock_en = 1;
    go(0, 6, 13, 6, 13, 3);

    finish_run();
  end

endmodule